// File: doc/BRIEF.md
# 2D Logical Register Descriptor Table

This block keeps the descriptors that split a square physical register array into a variable number of rectangular logical registers. Each descriptor has a top-left corner (row and column), a width, a height, an element type and a defined flag. At power-on, and again on a restore command, the array is tiled into equal square registers. Software can then redefine any entry at runtime, release it, or read it back.

Commands arrive one at a time on a valid/ready port. Each accepted command gets exactly one registered response on the cycle after acceptance. An element access (register id, row, column) returns the physical row and column. It is refused if the register is undefined or the index lies outside the rectangle. Two check commands tell the issue stage whether three register shapes suit a matrix product or an element-wise operation before that operation is sent. A global mode bit selects masked or unmasked execution.

Top module: `desc_table`

## Requirements
- R1: After reset, once `cmdReady` rises, entry i (0..15) has corner row 32*(i/4), corner column 32*(i%4), width 32, height 32, type code 5, and is defined. `regCount` reads 16 and `maskMode` reads 0.
- R2: An accepted command (`cmdValid` and `cmdReady` high at a clock edge) gives `rspValid` high for exactly the following cycle. In any cycle without a response, `rspValid` and all three fault flags are low.
- R3: Translate (op 0) on defined register A, with row r < height and column c < width, returns `rspRow` = corner row + r and `rspCol` = corner column + c, with no fault flag.
- R4: Translate with r >= height or c >= width raises `rspOob` and returns row and column 0.
- R5: Translate, multiply check (op 4) or element check (op 5) that names an undefined register raises `rspUndef` only, whatever the shapes are.
- R6: Define (op 1) on register D succeeds when corner row + height <= 128, corner column + width <= 128, both lengths are nonzero and the type code is at most 5 (0/1/2/3 = 8/16/32/64-bit integer, 4/5 = 32/64-bit float). The entry is then defined, and query (op 3) returns corner row in `rspRow`, corner column in `rspCol`, the lengths, the type and `rspDefined`=1. `regCount` tracks the number of defined entries.
- R7: A define whose rectangle passes row or column 127, or whose type code is 6 or 7, raises `rspOob` and leaves the table and `regCount` unchanged.
- R8: A define with width 0 or height 0 releases entry D. A later query shows `rspDefined`=0 with zero lengths, corner and type, and `regCount` drops by one if the entry was defined.
- R9: The multiply check flags `rspShape` unless width(A) = height(B), height(D) = height(A) and width(D) = width(B).
- R10: The element check flags `rspShape` unless A, B and D all have the same width and the same height.
- R11: Restore (op 2) brings back the table of R1. `cmdReady` is low for exactly 16 cycles after the restore is accepted, and `maskMode` is untouched.
- R12: Mode set (op 6) loads `maskMode` from `cmdFlag`. No other command changes it.
- R13: A response carries at most one of `rspUndef`, `rspOob`, `rspShape`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Command can be accepted (low while the table is restored) |
| cmdOp | input | 3 | 0 translate, 1 define, 2 restore, 3 query, 4 multiply check, 5 element check, 6 mode set, 7 no-op |
| cmdRegA | input | 4 | First operand / translated / queried register |
| cmdRegB | input | 4 | Second operand register |
| cmdRegD | input | 4 | Destination register / register to define |
| cmdRow | input | 7 | Element row, or corner row for define |
| cmdCol | input | 7 | Element column, or corner column for define |
| cmdWidth | input | 8 | Width for define |
| cmdHeight | input | 8 | Height for define |
| cmdType | input | 3 | Element type code for define |
| cmdFlag | input | 1 | Mode value for mode set |
| rspValid | output | 1 | Response present |
| rspUndef | output | 1 | Undefined register named |
| rspOob | output | 1 | Index out of bounds or define refused |
| rspShape | output | 1 | Operand shapes unsuitable |
| rspRow | output | 7 | Physical row, or queried corner row |
| rspCol | output | 7 | Physical column, or queried corner column |
| rspWidth | output | 8 | Queried width |
| rspHeight | output | 8 | Queried height |
| rspType | output | 3 | Queried type code |
| rspDefined | output | 1 | Queried entry is defined |
| regCount | output | 5 | Number of defined entries |
| maskMode | output | 1 | Masked execution selected |

## Verification
A corrupted descriptor field shows up at the ports on the first translate, query or shape check that names that entry, one cycle after the command is accepted. Random commands therefore read back every entry often, and every response is compared against a model of the table. A count that drifts from the defined flags is exposed by `regCount` in the cycle after the faulty update. A sweep that runs too short or too long changes how long `cmdReady` stays low, and leaves entries that later queries report wrongly.

// File: rtl/desc_pkg.sv
package desc_pkg;

  typedef enum logic [2:0] {
    OP_XLATE    = 3'd0,
    OP_DEFINE   = 3'd1,
    OP_RESETCFG = 3'd2,
    OP_QUERY    = 3'd3,
    OP_CHKMUL   = 3'd4,
    OP_CHKELEM  = 3'd5,
    OP_SETMODE  = 3'd6,
    OP_NOP      = 3'd7
  } op_t;

  typedef enum logic {ST_IDLE, ST_SWEEP} ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rspLoad;
    logic wrDefine;
    logic wrDefault;
    logic setMode;
    op_t  op;
  } ctl_t;

  localparam logic [2:0] TYPE_MAX     = 3'd5;
  localparam logic [2:0] DEFAULT_TYPE = 3'd5;

endpackage

// File: rtl/desc_ctl.sv
module desc_ctl
  import desc_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int IDW = $clog2(NUM_REGS)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmdValid,
  input  op_t            cmdOp,
  output logic           cmdReady,
  output ctl_t           ctl,
  output logic [IDW-1:0] defaultIdx
);

  ctlState_t state;
  logic [IDW-1:0] sweepIdx;
  logic accept;

  assign cmdReady   = (state == ST_IDLE);
  assign accept     = cmdValid && cmdReady;
  assign defaultIdx = sweepIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_SWEEP;
      sweepIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept && cmdOp == OP_RESETCFG) begin
            state    <= ST_SWEEP;
            sweepIdx <= '0;
          end
        end
        default: begin
          if (sweepIdx == IDW'(NUM_REGS - 1)) state <= ST_IDLE;
          else sweepIdx <= sweepIdx + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    ctl.rspLoad   = accept;
    ctl.wrDefine  = accept && (cmdOp == OP_DEFINE);
    ctl.wrDefault = (state == ST_SWEEP);
    ctl.setMode   = accept && (cmdOp == OP_SETMODE);
    ctl.op        = cmdOp;
  end

endmodule

// File: rtl/desc_dp.sv
module desc_dp
  import desc_pkg::*;
#(
  parameter int GRID     = 128,
  parameter int NUM_REGS = 16,
  parameter int DEF_SIDE = 4,
  localparam int CW      = $clog2(GRID),
  localparam int LW      = CW + 1,
  localparam int IDW     = $clog2(NUM_REGS),
  localparam int CNTW    = $clog2(NUM_REGS + 1),
  localparam int DEF_LEN = GRID / DEF_SIDE
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctl_t            ctl,
  input  logic [IDW-1:0]  defaultIdx,
  input  logic [IDW-1:0]  regA,
  input  logic [IDW-1:0]  regB,
  input  logic [IDW-1:0]  regD,
  input  logic [CW-1:0]   row,
  input  logic [CW-1:0]   col,
  input  logic [LW-1:0]   width,
  input  logic [LW-1:0]   height,
  input  logic [2:0]      dType,
  input  logic            flag,
  output logic            rspValid,
  output logic            rspUndef,
  output logic            rspOob,
  output logic            rspShape,
  output logic [CW-1:0]   rspRow,
  output logic [CW-1:0]   rspCol,
  output logic [LW-1:0]   rspWidth,
  output logic [LW-1:0]   rspHeight,
  output logic [2:0]      rspType,
  output logic            rspDefined,
  output logic [CNTW-1:0] regCount,
  output logic            maskMode
);

  logic [CW-1:0] tRow  [NUM_REGS];
  logic [CW-1:0] tCol  [NUM_REGS];
  logic [LW-1:0] tWid  [NUM_REGS];
  logic [LW-1:0] tHgt  [NUM_REGS];
  logic [2:0]    tType [NUM_REGS];
  logic          tDef  [NUM_REGS];

  // define legality
  logic defZero, defFits, defAccept, defWrite;
  always_comb begin
    defZero   = (width == '0) || (height == '0);
    defFits   = ((LW+1)'(row) + (LW+1)'(height) <= (LW+1)'(GRID)) &&
                ((LW+1)'(col) + (LW+1)'(width)  <= (LW+1)'(GRID));
    defAccept = defZero || (defFits && dType <= TYPE_MAX);
    defWrite  = ctl.wrDefine && defAccept;
  end

  // per-entry storage; default shape is a fixed tiling per index
  for (genvar i = 0; i < NUM_REGS; i++) begin : gEntry
    localparam int  DROW = (i / DEF_SIDE) * DEF_LEN;
    localparam int  DCOL = (i % DEF_SIDE) * DEF_LEN;
    localparam bit  DDEF = (i < DEF_SIDE * DEF_SIDE);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tRow[i] <= '0; tCol[i] <= '0; tWid[i] <= '0; tHgt[i] <= '0;
        tType[i] <= '0; tDef[i] <= 1'b0;
      end else if (ctl.wrDefault && defaultIdx == IDW'(i)) begin
        tRow[i]  <= DDEF ? CW'(DROW) : '0;
        tCol[i]  <= DDEF ? CW'(DCOL) : '0;
        tWid[i]  <= DDEF ? LW'(DEF_LEN) : '0;
        tHgt[i]  <= DDEF ? LW'(DEF_LEN) : '0;
        tType[i] <= DDEF ? DEFAULT_TYPE : '0;
        tDef[i]  <= DDEF;
      end else if (defWrite && regD == IDW'(i)) begin
        tRow[i]  <= defZero ? '0 : row;
        tCol[i]  <= defZero ? '0 : col;
        tWid[i]  <= defZero ? '0 : width;
        tHgt[i]  <= defZero ? '0 : height;
        tType[i] <= defZero ? '0 : dType;
        tDef[i]  <= !defZero;
      end
    end
  end

  // defined-entry count, updated by the single write per cycle
  logic oldDef, newDef, doWrite;
  always_comb begin
    doWrite = 1'b0; oldDef = 1'b0; newDef = 1'b0;
    if (ctl.wrDefault) begin
      doWrite = 1'b1;
      oldDef  = tDef[defaultIdx];
      newDef  = (int'(defaultIdx) < DEF_SIDE * DEF_SIDE);
    end else if (defWrite) begin
      doWrite = 1'b1;
      oldDef  = tDef[regD];
      newDef  = !defZero;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) regCount <= '0;
    else if (doWrite && newDef && !oldDef) regCount <= regCount + 1'b1;
    else if (doWrite && !newDef && oldDef) regCount <= regCount - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) maskMode <= 1'b0;
    else if (ctl.setMode) maskMode <= flag;
  end

  // operand lookup
  logic aDef, bDef, dDef;
  logic [LW-1:0] aW, aH, bW, bH, dW, dH;
  always_comb begin
    aDef = tDef[regA]; bDef = tDef[regB]; dDef = tDef[regD];
    aW = tWid[regA]; aH = tHgt[regA];
    bW = tWid[regB]; bH = tHgt[regB];
    dW = tWid[regD]; dH = tHgt[regD];
  end

  // response formation
  logic nUndef, nOob, nShape, nDef;
  logic [CW-1:0] nRow, nCol;
  logic [LW-1:0] nW, nH;
  logic [2:0] nType;
  always_comb begin
    nUndef = 1'b0; nOob = 1'b0; nShape = 1'b0; nDef = 1'b0;
    nRow = '0; nCol = '0; nW = '0; nH = '0; nType = '0;
    case (ctl.op)
      OP_XLATE: begin
        if (!aDef) nUndef = 1'b1;
        else if (LW'(row) >= aH || LW'(col) >= aW) nOob = 1'b1;
        else begin
          nRow = tRow[regA] + row;
          nCol = tCol[regA] + col;
        end
      end
      OP_DEFINE: nOob = !defAccept;
      OP_QUERY: begin
        if (aDef) begin
          nRow = tRow[regA]; nCol = tCol[regA];
          nW = aW; nH = aH; nType = tType[regA]; nDef = 1'b1;
        end
      end
      OP_CHKMUL: begin
        if (!(aDef && bDef && dDef)) nUndef = 1'b1;
        else nShape = (aW != bH) || (dH != aH) || (dW != bW);
      end
      OP_CHKELEM: begin
        if (!(aDef && bDef && dDef)) nUndef = 1'b1;
        else nShape = (aW != bW) || (aH != bH) || (dW != aW) || (dH != aH);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || !ctl.rspLoad) begin
      rspValid <= 1'b0; rspUndef <= 1'b0; rspOob <= 1'b0; rspShape <= 1'b0;
      rspRow <= '0; rspCol <= '0; rspWidth <= '0; rspHeight <= '0;
      rspType <= '0; rspDefined <= 1'b0;
    end else begin
      rspValid <= 1'b1; rspUndef <= nUndef; rspOob <= nOob; rspShape <= nShape;
      rspRow <= nRow; rspCol <= nCol; rspWidth <= nW; rspHeight <= nH;
      rspType <= nType; rspDefined <= nDef;
    end
  end

endmodule

// File: rtl/desc_table.sv
module desc_table
  import desc_pkg::*;
#(
  parameter int GRID     = 128,
  parameter int NUM_REGS = 16,
  parameter int DEF_SIDE = 4,
  localparam int CW   = $clog2(GRID),
  localparam int LW   = CW + 1,
  localparam int IDW  = $clog2(NUM_REGS),
  localparam int CNTW = $clog2(NUM_REGS + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  output logic            cmdReady,
  input  logic [2:0]      cmdOp,
  input  logic [IDW-1:0]  cmdRegA,
  input  logic [IDW-1:0]  cmdRegB,
  input  logic [IDW-1:0]  cmdRegD,
  input  logic [CW-1:0]   cmdRow,
  input  logic [CW-1:0]   cmdCol,
  input  logic [LW-1:0]   cmdWidth,
  input  logic [LW-1:0]   cmdHeight,
  input  logic [2:0]      cmdType,
  input  logic            cmdFlag,
  output logic            rspValid,
  output logic            rspUndef,
  output logic            rspOob,
  output logic            rspShape,
  output logic [CW-1:0]   rspRow,
  output logic [CW-1:0]   rspCol,
  output logic [LW-1:0]   rspWidth,
  output logic [LW-1:0]   rspHeight,
  output logic [2:0]      rspType,
  output logic            rspDefined,
  output logic [CNTW-1:0] regCount,
  output logic            maskMode
);

  ctl_t ctl;
  logic [IDW-1:0] defaultIdx;

  desc_ctl #(.NUM_REGS(NUM_REGS)) u_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(op_t'(cmdOp)),
    .cmdReady(cmdReady), .ctl(ctl), .defaultIdx(defaultIdx)
  );

  desc_dp #(.GRID(GRID), .NUM_REGS(NUM_REGS), .DEF_SIDE(DEF_SIDE)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .defaultIdx(defaultIdx),
    .regA(cmdRegA), .regB(cmdRegB), .regD(cmdRegD),
    .row(cmdRow), .col(cmdCol), .width(cmdWidth), .height(cmdHeight),
    .dType(cmdType), .flag(cmdFlag),
    .rspValid(rspValid), .rspUndef(rspUndef), .rspOob(rspOob), .rspShape(rspShape),
    .rspRow(rspRow), .rspCol(rspCol), .rspWidth(rspWidth), .rspHeight(rspHeight),
    .rspType(rspType), .rspDefined(rspDefined), .regCount(regCount), .maskMode(maskMode)
  );

endmodule

// File: rtl/desc_table_chk.sv
module desc_table_chk #(
  parameter int GRID     = 128,
  parameter int NUM_REGS = 16,
  localparam int CW   = $clog2(GRID),
  localparam int LW   = CW + 1,
  localparam int CNTW = $clog2(NUM_REGS + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            cmdValid,
  input logic            cmdReady,
  input logic [2:0]      cmdOp,
  input logic [CW-1:0]   cmdRow,
  input logic [CW-1:0]   cmdCol,
  input logic            cmdFlag,
  input logic            rspValid,
  input logic            rspUndef,
  input logic            rspOob,
  input logic            rspShape,
  input logic [CW-1:0]   rspRow,
  input logic [CW-1:0]   rspCol,
  input logic [LW-1:0]   rspWidth,
  input logic [LW-1:0]   rspHeight,
  input logic            rspDefined,
  input logic [CNTW-1:0] regCount,
  input logic            maskMode
);

  logic accept;
  logic [2:0] lastOp;
  logic [CW-1:0] lastRow, lastCol;
  assign accept = cmdValid && cmdReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastOp <= 3'd7; lastRow <= '0; lastCol <= '0;
    end else if (accept) begin
      lastOp <= cmdOp; lastRow <= cmdRow; lastCol <= cmdCol;
    end
  end

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> rspValid);  // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> !rspValid);  // R2
  AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !(rspUndef || rspOob || rspShape));  // R2
  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $onehot0({rspUndef, rspOob, rspShape}));  // R13
  AST_XLATE_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && lastOp == 3'd0 && !rspUndef && !rspOob) |->
      (rspRow >= lastRow && rspCol >= lastCol));  // R3
  AST_QUERY_INSIDE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && lastOp == 3'd3 && rspDefined) |->
      (rspWidth != '0 && rspHeight != '0 &&
       (LW+1)'(rspRow) + (LW+1)'(rspHeight) <= (LW+1)'(GRID) &&
       (LW+1)'(rspCol) + (LW+1)'(rspWidth)  <= (LW+1)'(GRID)));  // R6
  AST_RELEASED_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && lastOp == 3'd3 && !rspDefined) |->
      (rspWidth == '0 && rspHeight == '0));  // R8
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    regCount <= CNTW'(NUM_REGS));  // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (regCount == $past(regCount)) || (regCount == $past(regCount) + 1'b1) ||
    (regCount + 1'b1 == $past(regCount)));  // R8
  AST_SWEEP_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cmdOp == 3'd2) |=> !cmdReady);  // R11
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cmdOp == 3'd6) |=> (maskMode == $past(cmdFlag)));  // R12
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(accept && cmdOp == 3'd6) |=> $stable(maskMode));  // R12

endmodule

bind desc_table desc_table_chk #(.GRID(GRID), .NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdOp(cmdOp), .cmdRow(cmdRow), .cmdCol(cmdCol), .cmdFlag(cmdFlag),
  .rspValid(rspValid), .rspUndef(rspUndef), .rspOob(rspOob), .rspShape(rspShape),
  .rspRow(rspRow), .rspCol(rspCol), .rspWidth(rspWidth), .rspHeight(rspHeight),
  .rspDefined(rspDefined), .regCount(regCount), .maskMode(maskMode)
);

// File: tb/tb_desc_table.sv
module tb_desc_table;

  localparam int GRID = 128;
  localparam int NREG = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [2:0] cmdOp = '0;
  logic [3:0] cmdRegA = '0, cmdRegB = '0, cmdRegD = '0;
  logic [6:0] cmdRow = '0, cmdCol = '0;
  logic [7:0] cmdWidth = '0, cmdHeight = '0;
  logic [2:0] cmdType = '0;
  logic cmdFlag = 1'b0;
  logic rspValid, rspUndef, rspOob, rspShape, rspDefined, maskMode;
  logic [6:0] rspRow, rspCol;
  logic [7:0] rspWidth, rspHeight;
  logic [2:0] rspType;
  logic [4:0] regCount;

  always #2.5 clk = ~clk;  // 200 MHz

  desc_table dut (.*);

  int checks = 0;
  int errors = 0;

  // reference table
  int mRow[NREG], mCol[NREG], mW[NREG], mH[NREG], mT[NREG];
  bit mDef[NREG];
  bit mMode = 1'b0;

  function automatic void modelDefaults();
    for (int i = 0; i < NREG; i++) begin
      mRow[i] = 32 * (i / 4); mCol[i] = 32 * (i % 4);
      mW[i] = 32; mH[i] = 32; mT[i] = 5; mDef[i] = 1'b1;
    end
  endfunction

  function automatic int modelCount();
    int n = 0;
    for (int i = 0; i < NREG; i++) n += int'(mDef[i]);
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one command, response sampled at the negedge after acceptance
  task automatic doCmd(input int op, input int a, input int b, input int d,
                       input int r, input int c, input int w, input int h,
                       input int t, input bit f, input string reqIn);
    bit eU, eO, eS, eD;
    int eR, eC, eW, eH, eT;
    string req;
    longint act, exp;
    bit zero;
    eU = 0; eO = 0; eS = 0; eD = 0; eR = 0; eC = 0; eW = 0; eH = 0; eT = 0;
    req = reqIn;
    zero = (w == 0) || (h == 0);
    case (op)
      0: begin
        if (!mDef[a]) eU = 1;
        else if (r >= mH[a] || c >= mW[a]) eO = 1;
        else begin eR = mRow[a] + r; eC = mCol[a] + c; end
      end
      1: eO = !(zero || (r + h <= GRID && c + w <= GRID && t <= 5));
      3: if (mDef[a]) begin
           eR = mRow[a]; eC = mCol[a]; eW = mW[a]; eH = mH[a]; eT = mT[a]; eD = 1;
         end
      4: begin
        if (!(mDef[a] && mDef[b] && mDef[d])) eU = 1;
        else eS = (mW[a] != mH[b]) || (mH[d] != mH[a]) || (mW[d] != mW[b]);
      end
      5: begin
        if (!(mDef[a] && mDef[b] && mDef[d])) eU = 1;
        else eS = (mW[a] != mW[b]) || (mH[a] != mH[b]) ||
                  (mW[d] != mW[a]) || (mH[d] != mH[a]);
      end
      default: ;
    endcase
    @(negedge clk);
    cmdOp = 3'(op); cmdRegA = 4'(a); cmdRegB = 4'(b); cmdRegD = 4'(d);
    cmdRow = 7'(r); cmdCol = 7'(c); cmdWidth = 8'(w); cmdHeight = 8'(h);
    cmdType = 3'(t); cmdFlag = f; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    act = {rspValid, rspUndef, rspOob, rspShape, rspRow, rspCol, rspWidth,
           rspHeight, rspType, rspDefined};
    exp = {1'b1, eU, eO, eS, 7'(eR), 7'(eC), 8'(eW), 8'(eH), 3'(eT), eD};
    check(act == exp, req, "response", act, exp);
    check($onehot0({rspUndef, rspOob, rspShape}), "R13", "fault flags",
          {rspUndef, rspOob, rspShape}, 0);
    // model update
    if (op == 1 && !eO) begin
      if (zero) begin
        mDef[d] = 0; mRow[d] = 0; mCol[d] = 0; mW[d] = 0; mH[d] = 0; mT[d] = 0;
      end else begin
        mDef[d] = 1; mRow[d] = r; mCol[d] = c; mW[d] = w; mH[d] = h; mT[d] = t;
      end
    end
    if (op == 6) mMode = f;
    if (op == 2) begin
      int lowN = 0;
      while (!cmdReady && lowN < 100) begin lowN++; @(negedge clk); end
      check(lowN == NREG, "R11", "restore busy cycles", lowN, NREG);
      modelDefaults();
    end
    check(regCount == 5'(modelCount()), req, "regCount", regCount, modelCount());
    check(maskMode == mMode, "R12", "maskMode", maskMode, mMode);
  endtask

  function automatic int randLen();
    if ($urandom_range(0, 3) == 0) return $urandom_range(0, 130);
    return $urandom_range(0, 3);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelDefaults();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    begin
      int waitN = 0;
      while (!cmdReady && waitN < 100) begin waitN++; @(negedge clk); end
      check(waitN <= NREG + 1, "R1", "ready after reset", waitN, NREG);
    end
    check(regCount == 5'd16, "R1", "count after reset", regCount, 16);
    check(maskMode == 1'b0, "R1", "mode after reset", maskMode, 0);
    check(!rspValid, "R2", "no response idle", rspValid, 0);
    for (int i = 0; i < NREG; i++) doCmd(3, i, 0, 0, 0, 0, 0, 0, 0, 0, "R1");

    // translate
    doCmd(0, 5, 0, 0, 3, 31, 0, 0, 0, 0, "R3");
    doCmd(0, 15, 0, 0, 31, 31, 0, 0, 0, 0, "R3");
    doCmd(0, 5, 0, 0, 32, 0, 0, 0, 0, 0, "R4");
    doCmd(0, 5, 0, 0, 0, 32, 0, 0, 0, 0, "R4");
    @(negedge clk);
    check(!rspValid, "R2", "single-cycle response", rspValid, 0);

    // define at the grid edge, then refusals
    doCmd(1, 0, 0, 2, 100, 120, 8, 28, 2, 0, "R6");
    doCmd(3, 2, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
    doCmd(0, 2, 0, 0, 27, 7, 0, 0, 0, 0, "R3");
    doCmd(1, 0, 0, 3, 100, 121, 8, 28, 2, 0, "R7");
    doCmd(1, 0, 0, 3, 101, 0, 8, 28, 2, 0, "R7");
    doCmd(1, 0, 0, 3, 0, 0, 8, 8, 6, 0, "R7");
    doCmd(1, 0, 0, 3, 0, 0, 8, 8, 7, 0, "R7");
    doCmd(3, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R7");

    // release
    doCmd(1, 0, 0, 4, 0, 0, 0, 5, 1, 0, "R8");
    doCmd(3, 4, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    doCmd(1, 0, 0, 4, 0, 0, 5, 0, 1, 0, "R8");
    doCmd(0, 4, 0, 0, 0, 0, 0, 0, 0, 0, "R5");

    // shape checks
    doCmd(1, 0, 0, 0, 0, 0, 4, 2, 5, 0, "R6");
    doCmd(1, 0, 0, 1, 2, 0, 3, 4, 5, 0, "R6");
    doCmd(1, 0, 0, 6, 6, 0, 3, 2, 5, 0, "R6");
    doCmd(4, 0, 1, 6, 0, 0, 0, 0, 0, 0, "R9");
    doCmd(4, 0, 1, 7, 0, 0, 0, 0, 0, 0, "R9");
    doCmd(4, 1, 0, 6, 0, 0, 0, 0, 0, 0, "R9");
    doCmd(4, 0, 4, 6, 0, 0, 0, 0, 0, 0, "R5");
    doCmd(5, 7, 8, 9, 0, 0, 0, 0, 0, 0, "R10");
    doCmd(5, 7, 0, 9, 0, 0, 0, 0, 0, 0, "R10");
    doCmd(5, 7, 8, 6, 0, 0, 0, 0, 0, 0, "R10");
    doCmd(5, 7, 8, 4, 0, 0, 0, 0, 0, 0, "R5");

    // mask mode
    doCmd(6, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R12");
    doCmd(0, 9, 0, 0, 1, 1, 0, 0, 0, 0, "R12");
    doCmd(7, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");

    // restore
    doCmd(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    for (int i = 0; i < NREG; i++) doCmd(3, i, 0, 0, 0, 0, 0, 0, 0, 0, "R11");

    // random mix
    for (int it = 0; it < 1500; it++) begin
      int sel = $urandom_range(0, 99);
      int op;
      if (sel < 25) op = 0;
      else if (sel < 50) op = 1;
      else if (sel < 65) op = 3;
      else if (sel < 78) op = 4;
      else if (sel < 91) op = 5;
      else if (sel < 97) op = 6;
      else if (sel < 98) op = 2;
      else op = 7;
      doCmd(op, $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
            (op == 0) ? $urandom_range(0, 40) : $urandom_range(0, 127),
            (op == 0) ? $urandom_range(0, 40) : $urandom_range(0, 127),
            randLen(), randLen(), $urandom_range(0, 7), 1'($urandom_range(0, 1)),
            (op == 0) ? "R3" : (op == 1) ? "R6" : (op == 3) ? "R6" :
            (op == 4) ? "R9" : (op == 5) ? "R10" : (op == 2) ? "R11" : "R12");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule